// File: doc/BRIEF.md
# Power-On Reset Sequencer with Brown-Out Filter

This block turns a supply-good level into the active-low system reset of a chip. The supply-good input comes from an external comparator and is already synchronised to the block clock. While that level is low, the reset stays asserted. Once the level has been good for one full watchdog period, the reset is released. From then on, a supply drop that lasts longer than a short filter window is treated as a brown-out. A brown-out asserts reset again at once and restarts the whole power-up sequence. A drop no longer than the window is ignored.

The block also serves a window watchdog that sits beside it. It raises a one-cycle start pulse on the cycle the power-on delay ends, so the watchdog can open its first window. It drives a level that is high while the system is running. It also passes the watchdog clear input through only while the system is running. Before the first release, and at any time after a brown-out, clear pulses are ignored until a complete new power-on delay has elapsed. All times are counted in clock ticks and set by parameters.

Top module: `pwr_seq_top`

## Requirements
- R1: While the sequencer is in the supply-bad or delay phase and `supplyGood` is sampled low, `sysRstN` stays 0.
- R2: Starting from the supply-bad phase, `sysRstN` rises at the (TWD_TICKS+1)-th consecutive rising edge that samples `supplyGood` high. Before that edge it is 0.
- R3: While running, a run of at most FILT_TICKS consecutive low samples of `supplyGood` leaves `sysRstN` and `wdEnable` at 1.
- R4: While running, the edge that takes the (FILT_TICKS+1)-th consecutive low sample of `supplyGood` drives `sysRstN` and `wdEnable` to 0.
- R5: `wdClearOut` equals `wdClearIn` while `wdEnable` is 1, and is 0 otherwise.
- R6: After a brown-out, `wdClearIn` has no effect on `wdClearOut` until `supplyGood` has returned and the full power-on delay of R2 has elapsed again.
- R7: A single low sample of `supplyGood` during the power-on delay returns the sequencer to the supply-bad phase. The delay then counts again from zero when the supply recovers.
- R8: `wdRunPulse` is 1 for exactly one cycle, the first cycle in which `sysRstN` is 1 after a power-on delay. At all other times it is 0.
- R9: While `rstN` is 0, the block is in the supply-bad phase, with `sysRstN`, `wdEnable`, `wdRunPulse` and `wdClearOut` all at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rstN | input | 1 | Asynchronous active-low reset into the supply-bad phase |
| supplyGood | input | 1 | Synchronised supply-good level from the comparator |
| wdClearIn | input | 1 | Raw watchdog clear request from software |
| sysRstN | output | 1 | Active-low system reset |
| wdEnable | output | 1 | High while the system is running |
| wdRunPulse | output | 1 | One-cycle pulse when the power-on delay ends |
| wdClearOut | output | 1 | Clear request, gated to the running phase |

## Verification
A delay counter that is off by one shows as `sysRstN` and `wdRunPulse` moving one edge early or late, and this is visible at the release edge itself. A low-sample counter that is not cleared between drops shows up within a few cycles. It either releases a brown-out after a glitch of allowed length, or it misses a real one, and in both cases `sysRstN` is wrong right after the offending edge. A state that leaves the supply-bad or delay phase without completing the delay shows as `wdClearOut` following `wdClearIn` too early.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PH_BAD   = 2'd0,
    PH_DELAY = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef struct packed {
    logic dlyClr;
    logic dlyInc;
    logic lowClr;
    logic lowInc;
  } ctrl_strobe_t;

endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int TWD_TICKS  = 1000,
  parameter int FILT_TICKS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  output logic         delayDone,
  output logic         filtHit
);
  localparam int DLY_W  = (TWD_TICKS > 1) ? $clog2(TWD_TICKS) : 1;
  localparam int FILT_W = $clog2(FILT_TICKS + 1) + 1;
  localparam logic [DLY_W-1:0]  DLY_LAST = DLY_W'(TWD_TICKS - 1);
  localparam logic [FILT_W-1:0] FILT_MAX = FILT_W'(FILT_TICKS);

  logic [DLY_W-1:0]  dlyCnt;
  logic [FILT_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dlyCnt <= '0;
    else if (strobe.dlyClr) dlyCnt <= '0;
    else if (strobe.dlyInc) dlyCnt <= dlyCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowCnt <= '0;
    else if (strobe.lowClr) lowCnt <= '0;
    else if (strobe.lowInc) lowCnt <= lowCnt + 1'b1;
  end

  assign delayDone = (dlyCnt == DLY_LAST);
  assign filtHit   = (lowCnt == FILT_MAX);

  // R2: the delay count never passes its last value
  assert_dly_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    dlyCnt <= DLY_LAST);

  // R3: the low-sample count never runs past the filter length
  assert_low_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= FILT_MAX);

  // R7: a clear strobe always empties the delay counter
  assert_dly_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dlyClr |=> dlyCnt == '0);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         supplyGood,
  input  logic         delayDone,
  input  logic         filtHit,
  output ctrl_strobe_t strobe,
  output logic         running,
  output logic         runPulse
);
  phase_t phase, phaseNext;
  logic   pulseNext;

  always_comb begin
    phaseNext = phase;
    pulseNext = 1'b0;
    strobe    = '0;
    unique case (phase)
      PH_BAD: begin
        strobe.dlyClr = 1'b1;
        strobe.lowClr = 1'b1;
        if (supplyGood) phaseNext = PH_DELAY;
      end
      PH_DELAY: begin
        strobe.lowClr = 1'b1;
        if (!supplyGood) begin
          phaseNext     = PH_BAD;
          strobe.dlyClr = 1'b1;
        end else if (delayDone) begin
          phaseNext     = PH_RUN;
          pulseNext     = 1'b1;
          strobe.dlyClr = 1'b1;
        end else begin
          strobe.dlyInc = 1'b1;
        end
      end
      PH_RUN: begin
        strobe.dlyClr = 1'b1;
        if (supplyGood) begin
          strobe.lowClr = 1'b1;
        end else if (filtHit) begin
          phaseNext     = PH_BAD;
          strobe.lowClr = 1'b1;
        end else begin
          strobe.lowInc = 1'b1;
        end
      end
      default: begin
        phaseNext     = PH_BAD;
        strobe.dlyClr = 1'b1;
        strobe.lowClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_BAD;
      runPulse <= 1'b0;
    end else begin
      phase    <= phaseNext;
      runPulse <= pulseNext;
    end
  end

  assign running = (phase == PH_RUN);

  // R1: a low supply outside the run phase keeps the system held
  assert_hold_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !supplyGood) |=> !running);

  // R8: the start pulse lasts one cycle
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    runPulse |=> !runPulse);

  // R8: every entry into the run phase comes with the start pulse
  assert_pulse_on_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> runPulse);

  // R4: leaving the run phase needs a low supply sample
  assert_brownout_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    (running && supplyGood) |=> running);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int TWD_TICKS  = 1000,
  parameter int FILT_TICKS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  input  logic wdClearIn,
  output logic sysRstN,
  output logic wdEnable,
  output logic wdRunPulse,
  output logic wdClearOut
);
  ctrl_strobe_t strobe;
  logic delayDone, filtHit, running;

  pwr_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .delayDone  (delayDone),
    .filtHit    (filtHit),
    .strobe     (strobe),
    .running    (running),
    .runPulse   (wdRunPulse)
  );

  pwr_seq_dp #(
    .TWD_TICKS  (TWD_TICKS),
    .FILT_TICKS (FILT_TICKS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .delayDone (delayDone),
    .filtHit   (filtHit)
  );

  assign sysRstN    = running;
  assign wdEnable   = running;
  assign wdClearOut = wdClearIn & running;

  // R5: no clear reaches the watchdog while the system is held
  assert_clear_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sysRstN |-> !wdClearOut);

endmodule

// File: tb/pwr_seq_top_tb_top.sv
module pwr_seq_top_tb_top;
  localparam int TWD  = 16;
  localparam int FILT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0;
  logic wdClearIn = 1'b0;
  logic sysRstN, wdEnable, wdRunPulse, wdClearOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pwr_seq_top #(.TWD_TICKS(TWD), .FILT_TICKS(FILT)) dut_i (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .wdClearIn(wdClearIn),
    .sysRstN(sysRstN), .wdEnable(wdEnable), .wdRunPulse(wdRunPulse),
    .wdClearOut(wdClearOut)
  );

  // vector: [12] supplyGood, [11] wdClearIn, [10:3] edges to hold,
  //         [2] expected sysRstN, [1] expected wdEnable, [0] expected wdClearOut
  localparam int NVEC = 13;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'd5,  3'b000},  // R1 R5 supply bad
    {1'b1, 1'b1, 8'd10, 3'b000},  // R2 R5 inside delay
    {1'b1, 1'b0, 8'd6,  3'b000},  // R2 16 high samples, still held
    {1'b1, 1'b0, 8'd1,  3'b110},  // R2 17th high sample releases
    {1'b1, 1'b1, 8'd1,  3'b111},  // R5 clear passes while running
    {1'b0, 1'b0, 8'd3,  3'b110},  // R3 drop of FILT samples ignored
    {1'b1, 1'b0, 8'd2,  3'b110},  // R3 recovered
    {1'b0, 1'b0, 8'd4,  3'b000},  // R4 FILT+1 low samples
    {1'b0, 1'b1, 8'd2,  3'b000},  // R6 clear blocked after brown-out
    {1'b1, 1'b1, 8'd5,  3'b000},  // R6 blocked during new delay
    {1'b0, 1'b0, 8'd1,  3'b000},  // R7 drop inside delay
    {1'b1, 1'b1, 8'd16, 3'b000},  // R7 delay counted afresh
    {1'b1, 1'b1, 8'd1,  3'b111}   // R6 R7 released after full delay
  };

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic walk_edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R9: state held by reset
    repeat (3) @(negedge clk);
    wdClearIn  = 1'b1;
    supplyGood = 1'b1;
    #1;
    check("R9 sysRstN", sysRstN, 1'b0);
    check("R9 wdEnable", wdEnable, 1'b0);
    check("R9 wdRunPulse", wdRunPulse, 1'b0);
    check("R9 wdClearOut", wdClearOut, 1'b0);
    supplyGood = 1'b0;
    wdClearIn  = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      supplyGood = VEC[v][12];
      wdClearIn  = VEC[v][11];
      walk_edges(int'(VEC[v][10:3]));
      check($sformatf("vec%0d sysRstN", v), sysRstN, VEC[v][2]);
      check($sformatf("vec%0d wdEnable", v), wdEnable, VEC[v][1]);
      check($sformatf("vec%0d wdClearOut", v), wdClearOut, VEC[v][0]);
    end

    // R8: start pulse timing after a brown-out and a fresh power-up
    wdClearIn  = 1'b0;
    supplyGood = 1'b0;
    walk_edges(FILT + 1);
    check("R4 brown-out before pulse test", sysRstN, 1'b0);
    supplyGood = 1'b1;
    for (int e = 1; e <= TWD + 3; e++) begin
      walk_edges(1);
      check($sformatf("R8 pulse edge %0d", e), wdRunPulse, (e == TWD + 1));
      check($sformatf("R2 release edge %0d", e), sysRstN, (e >= TWD + 1));
    end

    // R9: asynchronous reset while running drops the outputs at once
    #1 rstN = 1'b0;
    #1;
    check("R9 async sysRstN", sysRstN, 1'b0);
    check("R9 async wdEnable", wdEnable, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    walk_edges(TWD);
    check("R2 held after async reset", sysRstN, 1'b0);
    walk_edges(1);
    check("R2 release after async reset", sysRstN, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule